// File: doc/BRIEF.md
# Capacitive Sensing Conversion Sequencer

This block sequences one capacitive-divider measurement around an external analog-to-digital converter. A trigger starts a pass: the sense node is first driven to a chosen level for a programmable number of cycles (precharge). Then it shares charge with the sampling capacitor for a second programmable number of cycles (acquisition). Only after that is the converter started. The converter is reached through a start pulse and a done strobe that carries a 10-bit unsigned sample.

With double sampling on, a measurement has two passes, and the second pass drives the node to the opposite level. The reported result is the signed difference of the first sample minus the second. In continuous mode one trigger runs both passes back to back. In step mode the sequencer parks after the first conversion, with busy low, and waits for a second trigger. A busy flag shows that a measurement is running. A sticky interrupt flag marks that a measurement has completed.

Top module: `cvd_seq`

## Requirements
- R1: After reset, busy, intFlag, chargeEn, chargeHigh, sampleEn and convStart are 0 and result is 0.
- R2: A goReq pulse while idle starts a pass. Busy is 1 from the next cycle until the measurement completes, and it is 0 again in the cycle after the final done strobe.
- R3: In each pass chargeEn is high for exactly preLen consecutive cycles. A preLen of 0 skips precharge.
- R4: After precharge, sampleEn is high for exactly acqLen cycles. An acqLen of 0 skips acquisition. chargeEn, sampleEn and convStart are never high together.
- R5: chargeHigh equals polSel during precharge of the first pass and equals the inverse of polSel during precharge of the second pass. It is 0 outside precharge.
- R6: After acquisition, convStart is high for exactly one cycle. The sequencer then waits any number of cycles for convDone, which qualifies convData.
- R7: With dblEn=1 and contEn=1, the second pass (precharge, acquisition, conversion) starts in the cycle after the first done strobe, with no further trigger.
- R8: With dblEn=1 and contEn=0, the sequencer parks after the first conversion with busy=0 and all phase outputs low, and intFlag is not set. The next goReq runs the second pass.
- R9: result is an 11-bit two's-complement value, updated at completion. It is first sample minus second sample when dblEn=1, and the zero-extended single sample when dblEn=0. It holds between completions.
- R10: intFlag goes to 1 in the cycle after the final done strobe and stays at 1 until intClr is high. If intClr is high in the same cycle that completion sets the flag, the set wins.
- R11: goReq while busy is high has no effect on phase timing or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| goReq | input | 1 | Trigger pulse |
| intClr | input | 1 | Clears the completion flag |
| preLen | input | 8 | Precharge length in cycles |
| acqLen | input | 8 | Acquisition length in cycles |
| polSel | input | 1 | Precharge level of the first pass |
| dblEn | input | 1 | Double-sampling enable |
| contEn | input | 1 | Run both passes from one trigger |
| convDone | input | 1 | Converter done strobe |
| convData | input | 10 | Converter sample, valid with convDone |
| busy | output | 1 | Measurement in progress |
| intFlag | output | 1 | Sticky completion flag |
| chargeEn | output | 1 | Precharge phase active |
| chargeHigh | output | 1 | Precharge drive level (1 = high) |
| sampleEn | output | 1 | Acquisition phase active |
| convStart | output | 1 | One-cycle converter start |
| result | output | 11 | Signed measurement result |

## Verification
Completion setting the interrupt flag and software clearing it can fall in the same cycle. The bench provokes this by raising intClr on the very edge that samples the final done strobe, on a third of the configurations in the sweep. It then expects the flag to read 1. One cycle later it confirms the flag stays set, and a lone clear afterwards must bring it to 0. A stray trigger is also placed in the middle of precharge, and the phase length measured at the pins must not change.

// File: rtl/cvd_pkg.sv
package cvd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACQ,
    ST_START,
    ST_WAIT,
    ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic loadPre;
    logic loadAcq;
    logic capFirst;
    logic capFinal;
    logic setInt;
  } dpStrobe_t;
endpackage

// File: rtl/cvd_ctrl.sv
module cvd_ctrl
  import cvd_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goReq,
  input  logic [LEN_W-1:0] preLen,
  input  logic [LEN_W-1:0] acqLen,
  input  logic             polSel,
  input  logic             dblEn,
  input  logic             contEn,
  input  logic             convDone,
  input  logic             cntLast,
  output dpStrobe_t        strb,
  output logic             busy,
  output logic             chargeEn,
  output logic             chargeHigh,
  output logic             sampleEn,
  output logic             convStart
);
  seqState_t stQ, stD;
  logic      passQ, passD;
  logic      launch;
  logic      preZero, acqZero;

  assign preZero = (preLen == '0);
  assign acqZero = (acqLen == '0);

  always_comb begin
    stD    = stQ;
    passD  = passQ;
    strb   = '0;
    launch = 1'b0;
    case (stQ)
      ST_IDLE: if (goReq) begin
        passD  = 1'b0;
        launch = 1'b1;
      end
      ST_HOLD: if (goReq) begin
        passD  = 1'b1;
        launch = 1'b1;
      end
      ST_PRE: if (cntLast) begin
        if (!acqZero) begin
          stD          = ST_ACQ;
          strb.loadAcq = 1'b1;
        end else begin
          stD = ST_START;
        end
      end
      ST_ACQ: if (cntLast) stD = ST_START;
      ST_START: stD = ST_WAIT;
      ST_WAIT: if (convDone) begin
        if (!passQ && dblEn) begin
          strb.capFirst = 1'b1;
          if (contEn) begin
            passD  = 1'b1;
            launch = 1'b1;
          end else begin
            stD = ST_HOLD;
          end
        end else begin
          strb.capFinal = 1'b1;
          strb.setInt   = 1'b1;
          stD           = ST_IDLE;
        end
      end
      default: stD = ST_IDLE;
    endcase
    if (launch) begin
      if (!preZero) begin
        stD          = ST_PRE;
        strb.loadPre = 1'b1;
      end else if (!acqZero) begin
        stD          = ST_ACQ;
        strb.loadAcq = 1'b1;
      end else begin
        stD = ST_START;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      passQ <= 1'b0;
    end else begin
      stQ   <= stD;
      passQ <= passD;
    end
  end

  assign busy       = (stQ != ST_IDLE) && (stQ != ST_HOLD);
  assign chargeEn   = (stQ == ST_PRE);
  assign chargeHigh = chargeEn & (polSel ^ passQ);
  assign sampleEn   = (stQ == ST_ACQ);
  assign convStart  = (stQ == ST_START);
endmodule

// File: rtl/cvd_dpath.sv
module cvd_dpath
  import cvd_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [LEN_W-1:0]    preLen,
  input  logic [LEN_W-1:0]    acqLen,
  input  logic                dblEn,
  input  logic                intClr,
  input  logic [SAMPLE_W-1:0] convData,
  output logic                cntLast,
  output logic                intFlag,
  output logic [SAMPLE_W:0]   result
);
  localparam int RES_W = SAMPLE_W + 1;

  logic [LEN_W-1:0]    cntQ;
  logic [SAMPLE_W-1:0] firstQ;
  logic [RES_W-1:0]    extFirst, extNow;

  assign extFirst = {1'b0, firstQ};
  assign extNow   = {1'b0, convData};
  assign cntLast  = (cntQ == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.loadPre) begin
      cntQ <= preLen;
    end else if (strb.loadAcq) begin
      cntQ <= acqLen;
    end else if (cntQ != '0) begin
      cntQ <= cntQ - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstQ <= '0;
      result <= '0;
    end else begin
      if (strb.capFirst) firstQ <= convData;
      if (strb.capFinal) result <= dblEn ? (extFirst - extNow) : extNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            intFlag <= 1'b0;
    else if (strb.setInt) intFlag <= 1'b1;
    else if (intClr)      intFlag <= 1'b0;
  end
endmodule

// File: rtl/cvd_seq.sv
module cvd_seq
  import cvd_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                goReq,
  input  logic                intClr,
  input  logic [LEN_W-1:0]    preLen,
  input  logic [LEN_W-1:0]    acqLen,
  input  logic                polSel,
  input  logic                dblEn,
  input  logic                contEn,
  input  logic                convDone,
  input  logic [SAMPLE_W-1:0] convData,
  output logic                busy,
  output logic                intFlag,
  output logic                chargeEn,
  output logic                chargeHigh,
  output logic                sampleEn,
  output logic                convStart,
  output logic [SAMPLE_W:0]   result
);
  dpStrobe_t strb;
  logic      cntLast;

  cvd_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .goReq(goReq), .preLen(preLen), .acqLen(acqLen),
    .polSel(polSel), .dblEn(dblEn), .contEn(contEn), .convDone(convDone),
    .cntLast(cntLast), .strb(strb), .busy(busy), .chargeEn(chargeEn),
    .chargeHigh(chargeHigh), .sampleEn(sampleEn), .convStart(convStart)
  );

  cvd_dpath #(.LEN_W(LEN_W), .SAMPLE_W(SAMPLE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .preLen(preLen), .acqLen(acqLen),
    .dblEn(dblEn), .intClr(intClr), .convData(convData), .cntLast(cntLast),
    .intFlag(intFlag), .result(result)
  );
endmodule

// File: rtl/cvd_seq_chk.sv
module cvd_seq_chk #(
  parameter int SAMPLE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              intClr,
  input logic              convDone,
  input logic              busy,
  input logic              intFlag,
  input logic              chargeEn,
  input logic              chargeHigh,
  input logic              sampleEn,
  input logic              convStart,
  input logic [SAMPLE_W:0] result
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R6
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({chargeEn, sampleEn, convStart})); // R4
  AST_LEVEL_IN_PRE: assert property (@(posedge clk) disable iff (!rstN)
    chargeHigh |-> chargeEn); // R5
  AST_QUIET_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!chargeEn && !sampleEn && !convStart)); // R8
  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !intClr) |=> intFlag); // R10
  AST_INT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> $past(convDone)); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(convDone) |-> $stable(result)); // R9
endmodule

bind cvd_seq cvd_seq_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/tb_cvd_seq.sv
module tb_cvd_seq;
  localparam int LEN_W    = 8;
  localparam int SAMPLE_W = 10;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                goReq = 1'b0;
  logic                intClr = 1'b0;
  logic [LEN_W-1:0]    preLen = '0;
  logic [LEN_W-1:0]    acqLen = '0;
  logic                polSel = 1'b0;
  logic                dblEn = 1'b0;
  logic                contEn = 1'b0;
  logic                convDone = 1'b0;
  logic [SAMPLE_W-1:0] convData = '0;
  logic                busy, intFlag, chargeEn, chargeHigh, sampleEn, convStart;
  logic [SAMPLE_W:0]   result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cvd_seq #(.LEN_W(LEN_W), .SAMPLE_W(SAMPLE_W)) dut (
    .clk(clk), .rstN(rstN), .goReq(goReq), .intClr(intClr), .preLen(preLen),
    .acqLen(acqLen), .polSel(polSel), .dblEn(dblEn), .contEn(contEn),
    .convDone(convDone), .convData(convData), .busy(busy), .intFlag(intFlag),
    .chargeEn(chargeEn), .chargeHigh(chargeHigh), .sampleEn(sampleEn),
    .convStart(convStart), .result(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic runMeas(input int pre, input int acq, input bit pol, input bit dbl,
                         input bit cont, input int d0, input int d1, input int lat,
                         input bit coinClr, input bit strayGo);
    int pc[2], ac[2], sc[2];
    int levelErr, busyErr, holdErr, waitLeft, pass, expRes;
    bit waiting, phaseEnd, finished, parkedSeen;
    int holdLeft;
    pc = '{0, 0}; ac = '{0, 0}; sc = '{0, 0};
    levelErr = 0; busyErr = 0; holdErr = 0; waitLeft = 0; pass = 0; holdLeft = 0;
    waiting = 0; phaseEnd = 0; finished = 0; parkedSeen = 0;
    @(negedge clk);
    preLen = LEN_W'(pre); acqLen = LEN_W'(acq);
    polSel = pol; dblEn = dbl; contEn = cont;
    goReq = 1'b1;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      goReq = 1'b0; convDone = 1'b0; intClr = 1'b0;
      if (phaseEnd) begin
        phaseEnd = 0;
        if (pass == 0 && dbl) begin
          if (cont) pass = 1;
          else begin
            holdLeft = 3; parkedSeen = 1;
            check(intFlag == 1'b0, "R8 no flag when parked", int'(intFlag), 0);
          end
        end else begin
          finished = 1;
        end
      end
      if (finished) break;
      if (holdLeft > 0) begin
        if (busy || chargeEn || sampleEn || convStart) holdErr++;
        holdLeft--;
        if (holdLeft == 0) begin goReq = 1'b1; pass = 1; end
        continue;
      end
      if (!busy) busyErr++;
      if (chargeEn) begin
        pc[pass]++;
        if (chargeHigh != (pol ^ pass[0])) levelErr++;
        if (strayGo && pass == 0 && pc[0] == 1) goReq = 1'b1;
      end else if (chargeHigh) levelErr++;
      if (sampleEn) ac[pass]++;
      if (convStart) begin
        sc[pass]++; waiting = 1; waitLeft = lat;
      end else if (waiting) begin
        if (strayGo) goReq = 1'b1;
        if (waitLeft == 0) begin
          convDone = 1'b1;
          convData = SAMPLE_W'(pass == 0 ? d0 : d1);
          if (coinClr && (pass == 1 || !dbl)) intClr = 1'b1;
          waiting = 0; phaseEnd = 1;
        end else waitLeft--;
      end
    end
    expRes = dbl ? (d0 - d1) : d0;
    check(finished, "R2 measurement completes", int'(finished), 1);
    check(pc[0] == pre, "R3 precharge length pass0", pc[0], pre);
    check(ac[0] == acq, "R4 acquisition length pass0", ac[0], acq);
    check(sc[0] == 1, "R6 single start pulse pass0", sc[0], 1);
    check(levelErr == 0, "R5 precharge level", levelErr, 0);
    check(busyErr == 0, "R2 busy while active", busyErr, 0);
    if (dbl) begin
      check(pc[1] == pre, "R7 precharge length pass1", pc[1], pre);
      check(ac[1] == acq, "R7 acquisition length pass1", ac[1], acq);
      check(sc[1] == 1, "R7 single start pulse pass1", sc[1], 1);
      check(parkedSeen == !cont, "R8 parks only in step mode", int'(parkedSeen), int'(!cont));
      check(holdErr == 0, "R8 quiet while parked", holdErr, 0);
    end
    check(busy == 1'b0, "R2 busy low at end", int'(busy), 0);
    check($signed(result) == expRes, "R9 result", int'($signed(result)), expRes);
    check(intFlag == 1'b1, "R10 flag set (coincident clear loses)", int'(intFlag), 1);
    @(negedge clk);
    check(intFlag == 1'b1, "R10 flag sticky", int'(intFlag), 1);
    intClr = 1'b1;
    @(negedge clk);
    intClr = 1'b0;
    check(intFlag == 1'b0, "R10 flag cleared", int'(intFlag), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && intFlag == 1'b0, "R1 reset flags", int'({busy, intFlag}), 0);
    check(!chargeEn && !chargeHigh && !sampleEn && !convStart, "R1 reset phases",
          int'({chargeEn, chargeHigh, sampleEn, convStart}), 0);
    check(result == '0, "R1 reset result", int'(result), 0);
    rstN = 1'b1;
    idx = 0;
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 4; a++)
        for (int m = 0; m < 8; m++) begin
          runMeas(p, a, m[0], m[1], m[2], (idx * 37 + 5) % 1024,
                  (idx * 91 + 1000) % 1024, idx % 3, (idx % 3) == 0, 1'b0);
          idx++;
        end
    runMeas(2, 1, 1'b0, 1'b1, 1'b1, 0, 1023, 0, 1'b0, 1'b0);
    runMeas(1, 2, 1'b1, 1'b1, 1'b0, 1023, 0, 4, 1'b0, 1'b0);
    runMeas(0, 0, 1'b0, 1'b0, 1'b0, 1023, 0, 0, 1'b1, 1'b0);
    runMeas(3, 2, 1'b1, 1'b0, 1'b0, 600, 0, 2, 1'b0, 1'b1); // R11
    runMeas(3, 2, 1'b0, 1'b1, 1'b1, 100, 700, 1, 1'b0, 1'b1); // R11
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule